// File: doc/BRIEF.md
# Byte-Lane Partitioned ALU

This block treats each 64-bit operand as eight independent unsigned 8-bit lanes. It performs one command each time the execute strobe is high. The commands are lane-wise addition, lane-wise subtraction, and three lane-wise comparisons of operand A against operand B: greater-than, less-than and not-equal. No carry or borrow crosses from one lane into the next.

Addition and subtraction write the wrapped lane values to the result register. They also write one flag per lane into a side register, the lane overflow register. A comparison writes a packed mask to the result: each lane's lowest bit holds that lane's answer, and its other seven bits are zero. A separate move command copies the lane overflow register into the result, so that a later stage can use the saved flags as an ordinary operand.

The control path decodes the opcode into a command class. The classes are IDLE (strobe low or a reserved opcode), ARITH (add or subtract), TEST (any comparison) and MOVE (copy flags). One clock edge commits the class: IDLE holds both registers; ARITH loads both; TEST and MOVE load only the result. The class is chosen again on every cycle, with no multi-cycle sequence, so each transition goes straight from the class of one cycle to the class of the next.

Top module: `bytewise_alu`

## Requirements
- R1: While reset is asserted and immediately after it is released, `result` is zero and `lane_ovf` is zero.
- R2: Opcode 0 (add) with `exec` high: on the next clock edge every lane k of `result` (bits 8k+7..8k) becomes (A_k + B_k) mod 256, with no carry into lane k+1.
- R3: Opcode 0 (add) sets `lane_ovf` bit k to the carry out of lane k's addition.
- R4: Opcode 1 (subtract) makes lane k of `result` equal to (A_k − B_k) mod 256. It sets `lane_ovf` bit k to 1 exactly when A_k < B_k, which is the borrow.
- R5: Opcode 2 (greater-than) makes bit 8k of `result` equal to 1 when A_k > B_k (unsigned) and 0 otherwise. Bits 8k+7..8k+1 become 0.
- R6: Opcode 3 (less-than) makes bit 8k of `result` equal to 1 when A_k < B_k (unsigned). All other bits of each lane become 0.
- R7: Opcode 4 (not-equal) makes bit 8k of `result` equal to 1 when A_k ≠ B_k. All other bits of each lane become 0.
- R8: The comparison opcodes 2, 3 and 4 leave `lane_ovf` unchanged.
- R9: Opcode 5 (move) loads `result` with `lane_ovf` in bits 7..0 and zero in bits 63..8. It leaves `lane_ovf` unchanged.
- R10: When `exec` is low, or when the opcode is 6 or 7 (reserved), `result` and `lane_ovf` both hold their values.
- R11: Each command commits in the single clock edge at which `exec` is sampled high. A move issued in the cycle right after an add or subtract returns the flags that the add or subtract produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec | input | 1 | Execute strobe; a command is taken on each edge where it is high |
| op_code | input | 3 | Command: 0 add, 1 subtract, 2 greater-than, 3 less-than, 4 not-equal, 5 move flags, 6–7 reserved |
| opnd_a | input | 64 | Operand A, eight unsigned lanes |
| opnd_b | input | 64 | Operand B, eight unsigned lanes |
| result | output | 64 | Registered result of the last committed command |
| lane_ovf | output | 8 | Lane overflow register; bit k belongs to lane k |

## Verification
Two functions can fall in the same cycle. An arithmetic command writes the overflow register at the same edge as the result, and a move issued in the very next cycle reads that register. The bench provokes this by keeping `exec` high across an add and an immediately following move. It judges the outcome by comparing the move's result with the carries that an independent lane model predicts for the add. It also checks that a comparison issued between an arithmetic command and a move does not disturb the flags the move returns.

// File: rtl/bwalu_pkg.sv
package bwalu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_GT   = 3'd2,
        OP_LT   = 3'd3,
        OP_NE   = 3'd4,
        OP_MOVE = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        CL_IDLE,
        CL_ARITH,
        CL_TEST,
        CL_MOVE
    } cmd_cl_e;

    typedef enum logic [1:0] {
        TS_GT,
        TS_LT,
        TS_NE
    } test_e;

endpackage

// File: rtl/bwalu_lane.sv
module bwalu_lane #(
    parameter int LW = 8
) (
    input  logic [LW-1:0] a,
    input  logic [LW-1:0] b,
    input  logic          sub,
    output logic [LW-1:0] sum,
    output logic          cout,
    output logic          zero
);
    logic [LW-1:0] b_eff;

    // One adder serves add, subtract and every comparison.
    assign b_eff = sub ? ~b : b;
    assign {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{LW{1'b0}}, sub};
    assign zero = (sum == {LW{1'b0}});

endmodule

// File: rtl/bwalu_decode.sv
module bwalu_decode
    import bwalu_pkg::*;
(
    input  logic       exec,
    input  logic [2:0] op,
    output cmd_cl_e    cls,
    output logic       sub_sel,
    output test_e      tsel
);
    always_comb begin
        cls     = CL_IDLE;
        sub_sel = 1'b0;
        tsel    = TS_NE;
        if (exec) begin
            unique case (op)
                OP_ADD: begin
                    cls = CL_ARITH;
                end
                OP_SUB: begin
                    cls     = CL_ARITH;
                    sub_sel = 1'b1;
                end
                OP_GT: begin
                    cls     = CL_TEST;
                    sub_sel = 1'b1;
                    tsel    = TS_GT;
                end
                OP_LT: begin
                    cls     = CL_TEST;
                    sub_sel = 1'b1;
                    tsel    = TS_LT;
                end
                OP_NE: begin
                    cls     = CL_TEST;
                    sub_sel = 1'b1;
                    tsel    = TS_NE;
                end
                OP_MOVE: begin
                    cls = CL_MOVE;
                end
                default: begin
                    cls = CL_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/bytewise_alu.sv
module bytewise_alu
    import bwalu_pkg::*;
#(
    parameter  int LANE_W = 8,
    parameter  int LANES  = 8,
    localparam int DATA_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec,
    input  logic [2:0]        op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] result,
    output logic [LANES-1:0]  lane_ovf
);
    localparam logic [DATA_W-1:0] LSB_MASK = {LANES{{{(LANE_W-1){1'b0}}, 1'b1}}};

    cmd_cl_e cls;
    logic    sub_sel;
    test_e   tsel;

    logic [DATA_W-1:0] sum_v;
    logic [DATA_W-1:0] mask_v;
    logic [LANES-1:0]  co_v;
    logic [LANES-1:0]  zero_v;
    logic [LANES-1:0]  flag_v;

    logic [DATA_W-1:0] result_q, result_d;
    logic [LANES-1:0]  ovf_q, ovf_d;

    bwalu_decode u_dec (
        .exec    (exec),
        .op      (op_code),
        .cls     (cls),
        .sub_sel (sub_sel),
        .tsel    (tsel)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic lt_b, gt_b, ne_b, hit;

        bwalu_lane #(.LW(LANE_W)) u_lane (
            .a    (opnd_a[g*LANE_W +: LANE_W]),
            .b    (opnd_b[g*LANE_W +: LANE_W]),
            .sub  (sub_sel),
            .sum  (sum_v[g*LANE_W +: LANE_W]),
            .cout (co_v[g]),
            .zero (zero_v[g])
        );

        // Comparisons read the difference A-B: no carry out means a borrow.
        assign lt_b = ~co_v[g];
        assign ne_b = ~zero_v[g];
        assign gt_b = co_v[g] & ne_b;

        always_comb begin
            unique case (tsel)
                TS_GT:   hit = gt_b;
                TS_LT:   hit = lt_b;
                default: hit = ne_b;
            endcase
        end

        assign mask_v[g*LANE_W +: LANE_W] = {{(LANE_W-1){1'b0}}, hit};
        assign flag_v[g] = co_v[g] ^ sub_sel;

        // R4: a lane's stored flag after a subtract equals its borrow.
        p_sub_borrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (exec && op_code == OP_SUB) |=>
                (ovf_q[g] == ($past(opnd_a[g*LANE_W +: LANE_W]) < $past(opnd_b[g*LANE_W +: LANE_W]))));
    end

    // Next-value process: one branch per command class.
    always_comb begin
        result_d = result_q;
        ovf_d    = ovf_q;
        unique case (cls)
            CL_ARITH: begin
                result_d = sum_v;
                ovf_d    = flag_v;
            end
            CL_TEST: begin
                result_d = mask_v;
            end
            CL_MOVE: begin
                result_d = {{(DATA_W-LANES){1'b0}}, ovf_q};
            end
            default: begin
                result_d = result_q;
            end
        endcase
    end

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            ovf_q    <= '0;
        end else begin
            result_q <= result_d;
            ovf_q    <= ovf_d;
        end
    end

    assign result   = result_q;
    assign lane_ovf = ovf_q;

    // R8, R9, R10: flags change only on add or subtract.
    p_ovf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec && (op_code == OP_ADD || op_code == OP_SUB)) |=> $stable(lane_ovf));

    // R10: no strobe, no change of result.
    p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !exec |=> $stable(result));

    // R5, R6, R7: comparisons leave only the lowest bit of each lane set.
    p_mask_form_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && (op_code == OP_GT || op_code == OP_LT || op_code == OP_NE))
            |=> ((result & ~LSB_MASK) == '0));

    // R9: a move returns the flags held before it.
    p_move_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op_code == OP_MOVE) |=>
            (result[DATA_W-1:LANES] == '0 && result[LANES-1:0] == $past(lane_ovf)));

endmodule

// File: tb/tb_bytewise_alu.sv
module tb_bytewise_alu;
    localparam int CLK_P = 10;
    localparam int NV    = 15;

    localparam logic [2:0] V_OP [NV] = '{
        3'd0, 3'd0, 3'd5, 3'd1, 3'd5, 3'd2, 3'd3, 3'd4, 3'd5, 3'd0, 3'd1, 3'd5, 3'd6, 3'd7, 3'd1};
    localparam logic [63:0] V_A [NV] = '{
        64'h0123_4567_89AB_CDEF, 64'hFF00_FF80_7F01_FE10, 64'h0, 64'h1000_FF05_0080_7F01, 64'h0,
        64'h10FF_0080_7F05_0001, 64'h10FF_0080_7F05_0001, 64'h10FF_0080_7F05_0001, 64'h0,
        64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 64'h1234_5678_9ABC_DEF0, 64'hAAAA_AAAA_AAAA_AAAA,
        64'h0000_0000_0000_0000};
    localparam logic [63:0] V_B [NV] = '{
        64'h1111_1111_1111_1111, 64'h0101_0000_8180_0210, 64'h0, 64'h2000_0106_0001_7F02, 64'h0,
        64'h0FFF_0180_7F06_0100, 64'h0FFF_0180_7F06_0100, 64'h0FFF_0180_7F06_0100, 64'h0,
        64'h0101_0101_0101_0101, 64'h0, 64'h0, 64'h1111_1111_1111_1111, 64'h5555_5555_5555_5555,
        64'hFF00_FF00_FF00_FF00};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic [63:0] result;
    logic [7:0]  lane_ovf;

    int runs = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [63:0] exp_res = '0;
    logic [7:0]  exp_c = '0;

    always #(CLK_P/2) clk = ~clk;

    bytewise_alu dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .exec     (exec),
        .op_code  (op_code),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .result   (result),
        .lane_ovf (lane_ovf)
    );

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R2";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Independent lane model built from the requirements.
    task automatic model(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r;
        logic [7:0]  c;
        r = exp_res;
        c = exp_c;
        for (int k = 0; k < 8; k++) begin
            int ak, bk;
            ak = int'(a[8*k +: 8]);
            bk = int'(b[8*k +: 8]);
            case (op)
                3'd0: begin r[8*k +: 8] = 8'((ak + bk) % 256); c[k] = (ak + bk) > 255; end
                3'd1: begin r[8*k +: 8] = 8'((ak - bk + 256) % 256); c[k] = ak < bk; end
                3'd2: r[8*k +: 8] = {7'd0, ak > bk};
                3'd3: r[8*k +: 8] = {7'd0, ak < bk};
                3'd4: r[8*k +: 8] = {7'd0, ak != bk};
                default: ;
            endcase
        end
        if (op == 3'd5) r = {56'd0, exp_c};
        exp_res = r;
        exp_c   = c;
    endtask

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] expv);
        runs++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] expv);
        runs++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s flags actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        exec = 1'b1; op_code = op; opnd_a = a; opnd_b = b;
        model(op, a, b);
        @(negedge clk);
        exec = 1'b0;
        check64(tag_of(op), result, exp_res);
        check8(op == 3'd0 ? "R3" : (op == 3'd1 ? "R4" : "R8"), lane_ovf, exp_c);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            runs++; fails++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check64("R1 in reset", result, 64'd0);
        check8("R1 in reset", lane_ovf, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check64("R1 after reset", result, 64'd0);
        check8("R1 after reset", lane_ovf, 8'd0);

        for (int i = 0; i < NV; i++) begin
            issue(V_OP[i], V_A[i], V_B[i]);
        end

        // R10: strobe low with an arithmetic opcode on the pins.
        issue(3'd0, 64'h8080_8080_8080_8080, 64'h8080_8080_8080_8080);
        @(negedge clk);
        op_code = 3'd1; opnd_a = 64'h0; opnd_b = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        check64("R10 strobe low", result, exp_res);
        check8("R10 strobe low", lane_ovf, exp_c);

        // R11: add then move in consecutive cycles, strobe held high.
        @(negedge clk);
        exec = 1'b1; op_code = 3'd0;
        opnd_a = 64'hF0F0_0F0F_FF01_8000; opnd_b = 64'h2020_F1F1_0100_8000;
        model(3'd0, opnd_a, opnd_b);
        @(negedge clk);
        check64("R11 add before move", result, exp_res);
        check8("R11 add flags", lane_ovf, exp_c);
        op_code = 3'd5;
        model(3'd5, opnd_a, opnd_b);
        @(negedge clk);
        exec = 1'b0;
        check64("R11 move after add", result, exp_res);

        // R8: comparison between subtract and move keeps the flags.
        issue(3'd1, 64'h0102_0304_0506_0708, 64'h0201_0403_0605_0807);
        issue(3'd3, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
        issue(3'd5, 64'h0, 64'h0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

endmodule